// File: doc/BRIEF.md
# Channel Estimate Frequency Smoother

This block refines a 64-bin complex channel estimate that sits in an external dual-port RAM. It replaces each occupied bin, from -26 to +26, with the mean of its neighbours across frequency. The results are written back into the same RAM. The I and Q parts are averaged separately, with identical windows.

**Bins and addresses.** A bin at signed position p lives at RAM address p mod 64. Bin -26 is address 38, bin -1 is address 63, the DC bin is address 0 and bin +26 is address 26. The null bins at addresses 27 to 37 are never written.

**Window.** Every window holds the bin and up to two neighbours on each side. Where the window would run past ±26, it is cut on the outside and divided by the smaller count. The DC bin is rebuilt from its four nearest neighbours and leaves out its own value.

**Division.** Each sum is a 19-bit signed value. It is divided by the window length in a small serial divider. The quotient truncates toward zero, and its low 16 bits are written back.

**Start and mode.** A one-cycle `start` launches a pass. The mode pins are sampled in the cycle `start` is taken.
- In legacy mode (`ht_mode` = 0), a pass runs unless `smooth_off` is high.
- In HT mode, a pass runs only when `smooth_req` is high and `smooth_off` is low.
- A skipped pass writes nothing and simply answers with `done`.

**Interface rules.** The RAM port is a plain memory port, not a stream. It has no valid/ready and no back-pressure: read data must appear exactly one cycle after `rd_en`, and a write completes in the cycle `wr_en` is high. No other agent may write the RAM during a pass.

Top module: `chest_smoother`

## Requirements
- R1: An interior bin p, with -24 <= p <= 24 and p != 0, is written with trunc((v[p-2]+v[p-1]+v[p]+v[p+1]+v[p+2])/5), rounded toward zero. This is done separately for I (the upper half of a RAM word) and Q (the lower half), keeping the low 16 bits.
- R2: The DC bin (address 0) is written with trunc((v[-2]+v[-1]+v[1]+v[2])/4). Its own value is excluded.
- R3: At the upper edge, bin 25 is written with the mean of bins 23..26 (divided by 4), and bin 26 with the mean of bins 24..26 (divided by 3).
- R4: At the lower edge, bin -26 (address 38) is written with the mean of bins -26..-24 (divided by 3), and bin -25 with the mean of bins -26..-23 (divided by 4).
- R5: Every window uses the values the RAM held before the pass, never results already written back. For example, bin +1 sees the original DC value.
- R6: A pass makes exactly 53 writes, in address order 38, 39, ..., 63, 0, 1, ..., 26. Addresses 27 to 37 keep their contents.
- R7: `done` is high for exactly one cycle, in the cycle right after the last write of a pass.
- R8: In legacy mode a pass runs when `smooth_off` is low. When `smooth_off` is high there are no writes, and `done` is high in the cycle after `start` is taken.
- R9: In HT mode a pass runs only when `smooth_req` is high and `smooth_off` is low. Otherwise it is skipped as in R8.
- R10: A `start` received while a pass is running is ignored. The pass still makes 53 writes and one `done`.
- R11: While and after reset, with no `start`, `rd_en`, `wr_en` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a pass |
| ht_mode | input | 1 | 0 = legacy occupancy rule, 1 = HT rule; sampled with start |
| smooth_req | input | 1 | Smoothing request, honoured in HT mode |
| smooth_off | input | 1 | Global disable of smoothing |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | 6 | RAM read address |
| rd_i | input | 16 | RAM read data, I part, valid one cycle after rd_en |
| rd_q | input | 16 | RAM read data, Q part, valid one cycle after rd_en |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 6 | RAM write address |
| wr_i | output | 16 | Smoothed I value to write |
| wr_q | output | 16 | Smoothed Q value to write |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two functions share a cycle at the end of a pass: the final write of bin +26 and the transition toward `done`. The bench logs the cycle of every write and of every `done`, and requires `done` to land exactly one cycle after the last logged write.

A second collision is a `start` that arrives while a division is in flight, with `smooth_off` raised at the same time. Taken wrongly, it would abort the pass or start a skip. The bench judges it by the write count, the number of `done` pulses, and a full comparison of the RAM against a model computed from the pre-pass contents.

// File: rtl/chsm_pkg.sv
package chsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_SUM,
    ST_DIV,
    ST_WRITE,
    ST_DONE
  } chsm_state_e;
endpackage

// File: rtl/chsm_span.sv
// Decides which window slots count for the bin at `center` and how many they are.
// Slot j holds bin center + HALF - j.
module chsm_span #(
  parameter int PW   = 8,
  parameter int HALF = 2,
  parameter int EDGE = 26,
  parameter int WIN  = 2 * HALF + 1,
  parameter int CW   = $clog2(WIN + 1)
) (
  input  logic signed [PW-1:0] center,
  output logic [WIN-1:0]       mask,
  output logic [CW-1:0]        cnt
);
  localparam logic signed [PW-1:0] EDGE_S = PW'(EDGE);

  for (genvar j = 0; j < WIN; j++) begin : g_slot
    localparam int OFF = HALF - j;
    logic signed [PW-1:0] pos;
    assign pos = center + $signed(PW'(OFF));
    // The centre slot of the DC bin is left out of its own average.
    if (OFF == 0) begin : g_mid
      assign mask[j] = (pos >= -EDGE_S) && (pos <= EDGE_S) && (center != '0);
    end else begin : g_side
      assign mask[j] = (pos >= -EDGE_S) && (pos <= EDGE_S);
    end
  end

  always_comb begin
    cnt = '0;
    for (int j = 0; j < WIN; j++) cnt = cnt + CW'(mask[j]);
  end
endmodule

// File: rtl/chsm_window.sv
// Shift register of original neighbour values and the masked window sum.
module chsm_window #(
  parameter int DW    = 16,
  parameter int WIN   = 5,
  parameter int SUM_W = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic signed [DW-1:0]    din,
  input  logic [WIN-1:0]          mask,
  output logic signed [SUM_W-1:0] sum
);
  logic signed [DW-1:0] taps [WIN];

  always_ff @(posedge clk) begin
    if (rst) taps[0] <= '0;
    else if (shift_en) taps[0] <= din;
  end

  for (genvar j = 1; j < WIN; j++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) taps[j] <= '0;
      else if (shift_en) taps[j] <= taps[j-1];
    end
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < WIN; j++)
      if (mask[j]) sum = sum + SUM_W'(taps[j]);
  end
endmodule

// File: rtl/chsm_div.sv
// Serial signed divider: one quotient bit per cycle, result truncated toward zero.
module chsm_div #(
  parameter int NW   = 19,
  parameter int DENW = 3,
  parameter int QW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [NW-1:0] num,
  input  logic [DENW-1:0]      den,
  output logic [QW-1:0]        quo,
  output logic                 done
);
  localparam int SW = $clog2(NW + 1);

  logic [NW-1:0]   work;
  logic [DENW-1:0] rem;
  logic [DENW-1:0] dreg;
  logic [SW-1:0]   steps;
  logic            neg;
  logic            busy;
  logic [NW-1:0]   mag;
  logic [DENW:0]   trial;
  logic            ge;

  assign mag   = num[NW-1] ? NW'(-num) : NW'(num);
  assign trial = {rem, work[NW-1]};
  assign ge    = trial >= {1'b0, dreg};

  always_ff @(posedge clk) begin
    if (rst) begin
      work  <= '0;
      rem   <= '0;
      dreg  <= '0;
      steps <= '0;
      neg   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        work  <= mag;
        rem   <= '0;
        dreg  <= den;
        neg   <= num[NW-1];
        steps <= SW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        work  <= {work[NW-2:0], ge};
        rem   <= ge ? DENW'(trial - {1'b0, dreg}) : trial[DENW-1:0];
        steps <= steps - 1'b1;
        if (steps == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = QW'(neg ? (~work + 1'b1) : work);

  p_div_den_r1: assert property (@(posedge clk) disable iff (rst) start |-> den != '0);
  p_div_idle_start_r1: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  p_div_done_once_r1: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

// File: rtl/chest_smoother.sv
module chest_smoother
  import chsm_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int EDGE = 26,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ht_mode,
  input  logic          smooth_req,
  input  logic          smooth_off,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] rd_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_i,
  output logic [DW-1:0] wr_q,
  output logic          done
);
  localparam int WIN   = 2 * HALF + 1;
  localparam int SUM_W = DW + $clog2(WIN);
  localparam int CW    = $clog2(WIN + 1);
  localparam int PW    = AW + 2;
  localparam int NBIN  = 1 << AW;
  localparam int NC    = 2;
  localparam logic signed [PW-1:0] EDGE_S = PW'(EDGE);
  localparam logic signed [PW-1:0] HALF_S = PW'(HALF);

  chsm_state_e          state;
  logic signed [PW-1:0] center;   // bin being smoothed
  logic signed [PW-1:0] ld;       // next bin to fetch
  logic                 run_ok;
  logic [WIN-1:0]       mask;
  logic [CW-1:0]        cnt;
  logic                 in_band;

  logic signed [DW-1:0]    cin   [NC];
  logic signed [SUM_W-1:0] csum  [NC];
  logic [DW-1:0]           cquo  [NC];
  logic [NC-1:0]           cdone;

  assign run_ok  = !smooth_off && (!ht_mode || smooth_req);
  assign in_band = (ld <= EDGE_S);
  assign cin[0]  = rd_i;
  assign cin[1]  = rd_q;

  chsm_span #(.PW(PW), .HALF(HALF), .EDGE(EDGE), .WIN(WIN), .CW(CW)) u_span (
    .center(center),
    .mask  (mask),
    .cnt   (cnt)
  );

  for (genvar c = 0; c < NC; c++) begin : g_comp
    logic signed [DW-1:0] din;
    // Past the upper edge nothing is read; the slot is masked out anyway.
    assign din = in_band ? cin[c] : '0;

    chsm_window #(.DW(DW), .WIN(WIN), .SUM_W(SUM_W)) u_win (
      .clk     (clk),
      .rst     (rst),
      .shift_en(state == ST_CAPT),
      .din     (din),
      .mask    (mask),
      .sum     (csum[c])
    );

    chsm_div #(.NW(SUM_W), .DENW(CW), .QW(DW)) u_div (
      .clk  (clk),
      .rst  (rst),
      .start(state == ST_SUM),
      .num  (csum[c]),
      .den  (cnt),
      .quo  (cquo[c]),
      .done (cdone[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      center <= '0;
      ld     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          if (run_ok) begin
            center <= -EDGE_S;
            ld     <= -EDGE_S;
            state  <= ST_FETCH;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_FETCH: state <= ST_CAPT;
        ST_CAPT: begin
          ld    <= ld + PW'(1);
          state <= (ld == center + HALF_S) ? ST_SUM : ST_FETCH;
        end
        ST_SUM: state <= ST_DIV;
        ST_DIV: if (&cdone) state <= ST_WRITE;
        ST_WRITE: begin
          if (center == EDGE_S) begin
            state <= ST_DONE;
          end else begin
            center <= center + PW'(1);
            state  <= ST_FETCH;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_en   = (state == ST_FETCH) && in_band;
  assign rd_addr = ld[AW-1:0];
  assign wr_en   = (state == ST_WRITE);
  assign wr_addr = center[AW-1:0];
  assign wr_i    = cquo[0];
  assign wr_q    = cquo[1];
  assign done    = (state == ST_DONE);

  p_dc_len_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUM && center == '0) |-> cnt == CW'(2 * HALF));
  p_upper_len_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUM && center == EDGE_S) |-> cnt == CW'(HALF + 1));
  p_lower_len_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUM && center == -EDGE_S) |-> cnt == CW'(HALF + 1));
  p_read_leads_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ld == center + HALF_S + PW'(1));
  p_wr_occupied_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= AW'(EDGE) || wr_addr >= AW'(NBIN - EDGE)));
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && center == EDGE_S) |=> done);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_skip_off_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && smooth_off) |=> (done && !wr_en));
  p_skip_ht_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && ht_mode && !smooth_req) |=> done);
  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIV && start) |=> (state == ST_DIV || state == ST_WRITE));
endmodule

// File: tb/sim_chest_smoother.sv
module sim_chest_smoother;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, ht_mode, smooth_req, smooth_off;
  logic rd_en, wr_en, done;
  logic [5:0] rd_addr, wr_addr;
  logic [15:0] rd_i, rd_q, wr_i, wr_q;

  chest_smoother u0 (
    .clk(clk), .rst(rst), .start(start), .ht_mode(ht_mode),
    .smooth_req(smooth_req), .smooth_off(smooth_off),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_i(rd_i), .rd_q(rd_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_i(wr_i), .wr_q(wr_q), .done(done)
  );

  // Bench-owned RAM with a one-cycle read and a loader port
  logic [31:0] mem [64];
  logic [5:0]  wlog [256];
  logic        ld_en;
  logic [5:0]  ld_a;
  logic [31:0] ld_d;
  int cyc = 0, wcnt = 0, dcnt = 0, wlast = 0, dlast = 0;
  int total = 0, bad = 0;
  int sI [64];
  int sQ [64];

  always @(posedge clk) begin
    if (rd_en) begin
      rd_i <= mem[rd_addr][31:16];
      rd_q <= mem[rd_addr][15:0];
    end
    if (ld_en) mem[ld_a] <= ld_d;
    else if (wr_en) begin
      mem[wr_addr]      <= {wr_i, wr_q};
      wlog[wcnt % 256] <= wr_addr;
      wcnt              <= wcnt + 1;
      wlast             <= cyc;
    end
    if (done) begin
      dcnt  <= dcnt + 1;
      dlast <= cyc;
    end
    cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int mode, input int idx, input bit q);
    case (mode)
      0: pat = q ? (((idx * 4243 + 17) % 30001) - 15000) : (((idx * 7919 + 5) % 20001) - 10000);
      1: pat = (idx == 0) ? (q ? -9000 : 10000) : (q ? -300 : 100);
      2: pat = q ? 32767 : -32768;
      default: pat = q ? (idx % 4) + 3 : -(idx % 3) - 7;
    endcase
  endfunction

  task automatic load(input int mode);
    for (int i = 0; i < 64; i++) begin
      sI[i] = pat(mode, i, 1'b0);
      sQ[i] = pat(mode, i, 1'b1);
      @(negedge clk);
      ld_en = 1'b1; ld_a = 6'(i); ld_d = {16'(sI[i]), 16'(sQ[i])};
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic int avg(input int pos, input bit q);
    int s, n, p;
    s = 0; n = 0;
    for (int o = -2; o <= 2; o++) begin
      p = pos + o;
      if (p >= -26 && p <= 26 && !(pos == 0 && o == 0)) begin
        s += q ? sQ[p & 63] : sI[p & 63];
        n++;
      end
    end
    avg = s / n;
  endfunction

  function automatic string tag_of(input int pos);
    if (pos > 26 || pos < -26) tag_of = "R6";
    else if (pos == 0) tag_of = "R2";
    else if (pos >= 25) tag_of = "R3";
    else if (pos <= -25) tag_of = "R4";
    else if (pos == 1 || pos == -1) tag_of = "R5";
    else tag_of = "R1";
  endfunction

  task automatic check_ram(input bit smoothed, input string why);
    for (int i = 0; i < 64; i++) begin
      int pos;
      logic [31:0] exp;
      pos = (i < 32) ? i : i - 64;
      if (smoothed && pos >= -26 && pos <= 26)
        exp = {16'(avg(pos, 1'b0)), 16'(avg(pos, 1'b1))};
      else
        exp = {16'(sI[i]), 16'(sQ[i])};
      check(mem[i] == exp, smoothed ? tag_of(pos) : why,
            $sformatf("bin %0d word", pos), mem[i], exp);
    end
  endtask

  // Launches a pass and checks the outcome; restart injects a start mid-pass (R10).
  task automatic run_case(input int mode, input bit ht, input bit req, input bit off,
                          input bit expect_run, input bit restart, input string why);
    int w0, d0, t;
    load(mode);
    w0 = wcnt; d0 = dcnt;
    @(negedge clk);
    ht_mode = ht; smooth_req = req; smooth_off = off; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!expect_run) begin
      check(done == 1'b1, why, "done one cycle after skipped start", done, 1);
      @(negedge clk);
      check(done == 1'b0, why, "done one cycle wide on skip", done, 0);
      check(wcnt == w0, why, "writes on skipped pass", wcnt - w0, 0);
      check_ram(1'b0, why);
      return;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      if (restart && t == 300) begin
        start = 1'b1; smooth_off = 1'b1;
        @(negedge clk);
        start = 1'b0; smooth_off = 1'b0;
      end
    end
    check(done == 1'b1, "R7", "done reached", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle wide", done, 0);
    @(negedge clk);
    check(wcnt - w0 == 53, restart ? "R10" : "R6", "write count", wcnt - w0, 53);
    check(dcnt - d0 == 1, restart ? "R10" : "R7", "done count", dcnt - d0, 1);
    check(dlast == wlast + 1, "R7", "done cycle vs last write", dlast, wlast + 1);
    for (int k = 0; k < 53 && k < wcnt - w0; k++) begin
      logic [5:0] ea;
      ea = 6'((k - 26) & 63);
      if (wlog[(w0 + k) % 256] != ea) begin
        check(1'b0, "R6", $sformatf("write order slot %0d", k), wlog[(w0 + k) % 256], ea);
        break;
      end
    end
    check_ram(1'b1, why);
    ht_mode = 1'b0; smooth_req = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!rd_en && !wr_en && !done, "R11", "strobes in reset", {rd_en, wr_en, done}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!rd_en && !wr_en && !done, "R11", "strobes idle after reset", {rd_en, wr_en, done}, 0);
  endtask

  task automatic t_legacy_mixed;   run_case(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1"); endtask
  task automatic t_dc_spike;       run_case(1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5"); endtask
  task automatic t_full_scale;     run_case(2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1"); endtask
  task automatic t_neg_trunc;      run_case(3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1"); endtask
  task automatic t_legacy_off;     run_case(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8"); endtask
  task automatic t_ht_no_req;      run_case(1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9"); endtask
  task automatic t_ht_req_off;     run_case(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9"); endtask
  task automatic t_ht_req;         run_case(3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R9"); endtask
  task automatic t_restart_busy;   run_case(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10"); endtask

  initial begin
    start = 1'b0; ht_mode = 1'b0; smooth_req = 1'b0; smooth_off = 1'b0;
    ld_en = 1'b0; ld_a = '0; ld_d = '0; rst = 1'b1;
    t_reset();
    t_legacy_mixed();
    t_dc_spike();
    t_full_scale();
    t_neg_trunc();
    t_legacy_off();
    t_ht_no_req();
    t_ht_req_off();
    t_ht_req();
    t_restart_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule